// File: doc/BRIEF.md
# Synchronized Decimation Timing Controller

This block paces the back end of a decimating filter that is fed by an oversampled 1-bit modulator stream. It takes one system clock and produces three outputs. The first is a modulator-sync pulse that realigns the modulator's bit framing. The second is a data-ready strobe that marks each output-word boundary. The third is a state code that reports idle, running or powered down. The output period is a power of two times a base count, and a single counter that a sync edge clears produces all seven periods.

The rate code and the power-down request can come from two sources, chosen by a mode input. One is the device pins. The other is a pair of configuration bits that are latched by a write strobe. Conversion never starts by itself. After reset or after power-down is left, the block waits in idle until it sees a low-to-high transition on the sync input. Any later sync edge restarts the period count and loads the rate selected at that moment.

Top module: `dec_timing_ctrl`

## Requirements
- R1: While `rst_ni` is low and directly after it, `state_o` is 0 (idle), `drdy_o` is 0 and `msync_o` is 0.
- R2: In idle, `drdy_o` stays low for any length of time until a sync event is accepted.
- R3: A sync event is a clock edge at which `sync_i` is high and it was low at the previous edge. When the block is not powered down, the event is accepted: `state_o` becomes 1 (running) and `msync_o` is high for exactly the next cycle.
- R4: While running, `drdy_o` is high for one cycle every P clocks, with P = BASE_CYCLES << code for rate codes 0..6 (256 to 16384 clocks by default). The first strobe follows the accept edge by exactly P edges.
- R5: Rate code 7 gives the same period as code 6.
- R6: Holding `sync_i` high does not retrigger, so the count continues without a restart.
- R7: A change of rate code while running takes effect only at the next accepted sync event.
- R8: A sync event while running restarts the count from the accept edge, and no strobe from the old schedule appears.
- R9: When the effective power-down request is high, the next edge enters power-down (`state_o` = 2). There `drdy_o` and `msync_o` stay low and sync edges are ignored. The first edge with the request low moves the block to idle.
- R10: With `hw_mode_i` high, `rate_pin_i` and `pwdn_pin_i` control the block. With it low, the values stored from `cfg_rate_i` and `cfg_pwdn_i` at the last edge with `cfg_we_i` high control it, and the pins are ignored.
- R11: `drdy_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_mode_i | input | 1 | 1: pins control; 0: stored configuration controls |
| rate_pin_i | input | 3 | Rate code from pins |
| pwdn_pin_i | input | 1 | Power-down request from pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rate_i | input | 3 | Rate code to store |
| cfg_pwdn_i | input | 1 | Power-down bit to store |
| sync_i | input | 1 | Synchronizing input, rising edge significant |
| msync_o | output | 1 | One-cycle modulator-sync pulse |
| drdy_o | output | 1 | One-cycle output-word strobe |
| state_o | output | 2 | 0 idle, 1 running, 2 powered down |

## Verification
The hardest situation to reach from the ports is a resync in the middle of a period. In that case the old schedule's next strobe must vanish while the new one is timed from the new accept edge. The bench gets there by re-raising sync a few hundred clocks into a long period. It queues only the strobes of the new schedule, so a stray old strobe shows up as an unexpected item. Power-down entry through the stored bits is reached by switching the mode input low while the pins request the opposite value.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PWDN = 2'd2
  } dtc_state_e;
endpackage

// File: rtl/dtc_ctrl_src.sv
module dtc_ctrl_src #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_mode_i,
  input  logic [RATE_W-1:0] rate_pin_i,
  input  logic              pwdn_pin_i,
  input  logic              cfg_we_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              cfg_pwdn_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              pwdn_o
);
  logic [RATE_W-1:0] cfg_rate_q;
  logic              cfg_pwdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rate_q <= '0;
      cfg_pwdn_q <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_rate_q <= cfg_rate_i;
      cfg_pwdn_q <= cfg_pwdn_i;
    end
  end

  assign rate_o = hw_mode_i ? rate_pin_i : cfg_rate_q;
  assign pwdn_o = hw_mode_i ? pwdn_pin_i : cfg_pwdn_q;
endmodule

// File: rtl/dtc_sync_edge.sv
module dtc_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  // reset to 1: a level held through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b1;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/dtc_period_cnt.sv
module dtc_period_cnt #(
  parameter int BASE_CYCLES = 256,
  parameter int NUM_RATES   = 7,
  parameter int RATE_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int CNT_W = $clog2(BASE_CYCLES) + NUM_RATES - 1;
  localparam logic [RATE_W-1:0] MAX_CODE = RATE_W'(NUM_RATES - 1);

  logic [RATE_W-1:0] rate_q, sel;
  logic [CNT_W-1:0]  cnt_q, last_w;

  always_comb begin
    sel    = (rate_q > MAX_CODE) ? MAX_CODE : rate_q;
    last_w = CNT_W'((BASE_CYCLES << sel) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rate_q <= '0;
    end else if (load_i) begin
      cnt_q  <= '0;
      rate_q <= rate_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == last_w) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i & (cnt_q == last_w);
endmodule

// File: rtl/dec_timing_ctrl.sv
module dec_timing_ctrl
  import dtc_pkg::*;
#(
  parameter int BASE_CYCLES = 256,
  parameter int NUM_RATES   = 7,
  parameter int RATE_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_mode_i,
  input  logic [RATE_W-1:0] rate_pin_i,
  input  logic              pwdn_pin_i,
  input  logic              cfg_we_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              cfg_pwdn_i,
  input  logic              sync_i,
  output logic              msync_o,
  output logic              drdy_o,
  output logic [1:0]        state_o
);
  dtc_state_e        state_q;
  logic [RATE_W-1:0] rate_eff;
  logic              pwdn_eff, sync_rise, accept, tick;
  logic              msync_q, drdy_q;

  dtc_ctrl_src #(.RATE_W(RATE_W)) u_src (
    .clk_i, .rst_ni, .hw_mode_i, .rate_pin_i, .pwdn_pin_i,
    .cfg_we_i, .cfg_rate_i, .cfg_pwdn_i,
    .rate_o (rate_eff),
    .pwdn_o (pwdn_eff)
  );

  dtc_sync_edge u_edge (
    .clk_i, .rst_ni, .sync_i,
    .rise_o (sync_rise)
  );

  assign accept = sync_rise & ~pwdn_eff & (state_q != ST_PWDN);

  dtc_period_cnt #(
    .BASE_CYCLES(BASE_CYCLES), .NUM_RATES(NUM_RATES), .RATE_W(RATE_W)
  ) u_cnt (
    .clk_i, .rst_ni,
    .load_i (accept | pwdn_eff),
    .run_i  ((state_q == ST_RUN) & ~pwdn_eff),
    .rate_i (rate_eff),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      msync_q <= 1'b0;
      drdy_q  <= 1'b0;
    end else begin
      if (pwdn_eff)                state_q <= ST_PWDN;
      else if (state_q == ST_PWDN) state_q <= ST_IDLE;
      else if (accept)             state_q <= ST_RUN;
      msync_q <= accept;
      drdy_q  <= tick & ~accept;  // resync drops the old boundary
    end
  end

  assign msync_o = msync_q;
  assign drdy_o  = drdy_q;
  assign state_o = state_q;
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       drdy_o,
  input logic       msync_o,
  input logic [1:0] state_o,
  input logic       pwdn_eff
);
  // R11
  drdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |=> !drdy_o);
  // R3
  msync_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msync_o |-> state_o == 2'd1);
  // R3
  msync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msync_o |=> !msync_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> !drdy_o);
  // R9
  pwdn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> !drdy_o && !msync_o);
  // R9
  pwdn_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_eff |=> state_o == 2'd2);
  // R9
  pwdn_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 && !pwdn_eff |=> state_o == 2'd0);
endmodule

bind dec_timing_ctrl dtc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .drdy_o   (drdy_o),
  .msync_o  (msync_o),
  .state_o  (state_o),
  .pwdn_eff (pwdn_eff)
);

// File: tb/dec_timing_ctrl_tb.sv
module dec_timing_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_mode_i = 1'b1;
  logic [2:0] rate_pin_i = '0;
  logic       pwdn_pin_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_rate_i = '0;
  logic       cfg_pwdn_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       msync_o, drdy_o;
  logic [1:0] state_o;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  dec_timing_ctrl u_dut (
    .clk_i, .rst_ni, .hw_mode_i, .rate_pin_i, .pwdn_pin_i,
    .cfg_we_i, .cfg_rate_i, .cfg_pwdn_i, .sync_i,
    .msync_o, .drdy_o, .state_o
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected strobe cycles as drdy_o appears
  always @(negedge clk_i) if (rst_ni && !done) begin
    if (exp_q.size() > 0 && exp_q[0] < cyc) begin
      vectors++; fails++;
      $display("FAIL R4: strobe missing, actual none expected cycle %0d", exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (drdy_o) begin
      vectors++;
      if (exp_q.size() > 0 && exp_q[0] == cyc) void'(exp_q.pop_front());
      else begin
        fails++;
        $display("FAIL R2/R8: unexpected strobe, actual cycle %0d expected %0d",
                 cyc, exp_q.size() > 0 ? exp_q[0] : -1);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drives a sync edge; returns the accept edge index
  task automatic sync_edge(output int c0);
    sync_i = 1'b0;
    @(negedge clk_i);
    c0 = cyc + 1;
    sync_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic start_run(input int per, input int n, output int c0);
    sync_edge(c0);
    check("R3 msync", msync_o, 1);
    check("R3 state", state_o, 1);
    for (int k = 1; k <= n; k++) exp_q.push_back(c0 + k * per);
  endtask

  initial begin
    int c0;
    wait_cyc(3);
    check("R1 state", state_o, 0);
    check("R1 drdy", drdy_o, 0);
    check("R1 msync", msync_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 state", state_o, 0);
    // R2: idle stays quiet
    wait_cyc(600);
    check("R2 idle", state_o, 0);

    // R4/R6: code 0 with sync held high
    start_run(BASE, 3, c0);
    wait_cyc(3 * BASE);
    check("R6 still run", state_o, 1);
    // R7: change pins mid-run, schedule keeps old rate
    rate_pin_i = 3'd3;
    for (int k = 4; k <= 5; k++) exp_q.push_back(c0 + k * BASE);
    wait_cyc(2 * BASE);
    // R7: new rate applies at next sync
    start_run(BASE << 3, 2, c0);
    wait_cyc(2 * (BASE << 3));
    // R8: resync mid-period, old strobe must not appear
    wait_cyc(300);
    rate_pin_i = 3'd0;
    start_run(BASE, 2, c0);
    wait_cyc(2 * BASE);

    // R4/R5: other codes
    for (int r = 1; r <= 7; r++) begin
      int sh;
      sh = (r > 6) ? 6 : r;
      rate_pin_i = 3'(r);
      if (r == 3) continue;
      start_run(BASE << sh, 1, c0);
      wait_cyc(BASE << sh);
    end

    // R9: pin power-down
    pwdn_pin_i = 1'b1;
    @(negedge clk_i);
    check("R9 enter", state_o, 2);
    check("R9 drdy", drdy_o, 0);
    sync_edge(c0);
    check("R9 sync ignored msync", msync_o, 0);
    check("R9 sync ignored state", state_o, 2);
    wait_cyc(300);
    pwdn_pin_i = 1'b0;
    @(negedge clk_i);
    check("R9 exit idle", state_o, 0);
    wait_cyc(300);
    check("R9 idle waits", state_o, 0);
    rate_pin_i = 3'd0;
    start_run(BASE, 1, c0);
    wait_cyc(BASE);

    // R10: configuration source
    cfg_rate_i = 3'd2; cfg_pwdn_i = 1'b0; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    hw_mode_i = 1'b0;
    pwdn_pin_i = 1'b1;  // ignored in config mode
    @(negedge clk_i);
    check("R10 pin pwdn ignored", state_o, 1);
    start_run(BASE << 2, 1, c0);
    wait_cyc(BASE << 2);
    cfg_pwdn_i = 1'b1; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    @(negedge clk_i);
    check("R10 cfg pwdn", state_o, 2);
    cfg_pwdn_i = 1'b0; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    wait_cyc(2);
    check("R10 cfg exit", state_o, 0);
    wait_cyc(20);
    check("R4 queue drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule